// File: doc/BRIEF.md
# DMA Channel Slot Sequencer

This block is the control sequencer of one DMA channel in a small microcontroller. Every clock cycle it decides who owns the shared bus: the DMA channel, which then performs one byte transfer, or the CPU, which then executes an instruction cycle. Software programs the channel through a single configuration write. That write carries the start bit, a two-bit mode, an interrupt enable, a FIFO-target flag and the byte count. The sequencer then runs the job to completion and reports it through a done flag and a completion interrupt.

Four modes are supported. Burst owns the bus on every cycle until the count is exhausted. Demand owns the bus whenever the demand request is present and otherwise yields to the CPU. Alternate-cycle forces strict DMA/CPU interleave. Alternate-demand serves demand requests but always inserts one CPU cycle after each transfer. While the channel is busy with a FIFO target, the FIFO's own service interrupt is masked. During a burst, no interrupt output is raised. Address generation and the data path are outside this block. Each DMA cycle is marked by `xfer_strobe` and each CPU cycle by `cpu_slot`.

The state machine has seven states. IDLE is the channel stopped. BURST is a transfer on every cycle. DMD_ARMED is plain demand, transferring while demand is high. ALT_RUN and ALT_GAP are the transfer and CPU halves of alternate-cycle mode. ADM_ARMED and ADM_GAP are the armed and forced-CPU halves of alternate-demand mode. A write with start set and a non-zero count moves IDLE or any state to the mode's entry state: BURST, DMD_ARMED, ALT_RUN or ADM_ARMED. Any other write returns to IDLE. ALT_RUN goes to ALT_GAP and ALT_GAP goes back to ALT_RUN. ADM_ARMED goes to ADM_GAP on a transfer, and ADM_GAP goes back to ADM_ARMED. The transfer that takes the count from one to zero returns every running state to IDLE.

Top module: `dma_slot_sequencer`

## Requirements
- R1: After reset, `go_o`, `done_o`, `count_o`, `xfer_strobe`, `dma_irq` and `fifo_irq` are all zero, and `cpu_slot` is one.
- R2: A write (`cfg_we`=1) loads the count from `cfg_count`. With `cfg_go`=1 and a non-zero count, it sets `go_o` and clears `done_o` from the next cycle. With `cfg_go`=0, transfers stop from the next cycle and `done_o` keeps its value. The mode encoding is 0 burst, 1 demand, 2 alternate-cycle, 3 alternate-demand.
- R3: Each `xfer_strobe` cycle decrements `count_o` by one. On the cycle after the strobe that takes the count to zero, `go_o` is 0 and `done_o` is 1.
- R4: In burst mode, `xfer_strobe` is high on N consecutive cycles starting in the cycle after the write, where N is the count. `dreq` is ignored.
- R5: In demand mode, `xfer_strobe` is high exactly on the cycles where `dreq` is high while `go_o` is set. No CPU cycle is granted while demand is present.
- R6: In alternate-cycle mode, transfers and CPU cycles strictly alternate, starting with a transfer, independent of `dreq`. N transfers take 2N-1 cycles.
- R7: In alternate-demand mode, a transfer occurs on a cycle with `dreq` high unless the previous cycle was a transfer. After each transfer, one CPU cycle is forced even if `dreq` stays high.
- R8: `dma_irq` equals `done_o` AND the latched interrupt enable, and is low while a burst is in progress.
- R9: A one-cycle `int_ack` while `done_o` is set clears `done_o` from the next cycle.
- R10: `fifo_irq` follows `fifo_req`. It is forced low while `go_o` is set with the FIFO-target flag latched, and while a burst is in progress.
- R11: A write with `cfg_go`=1 and `cfg_count`=0 gives `go_o`=0 and `done_o`=1 on the next cycle, with no transfer.
- R12: `cpu_slot` is high on exactly the cycles where `xfer_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_go | input | 1 | Start bit carried by the write |
| cfg_mode | input | 2 | Mode: 0 burst, 1 demand, 2 alternate, 3 alternate-demand |
| cfg_ie | input | 1 | Completion interrupt enable |
| cfg_fifo | input | 1 | Channel targets the FIFO |
| cfg_count | input | CW | Byte count to load |
| dreq | input | 1 | Demand request |
| fifo_req | input | 1 | Raw FIFO service request |
| int_ack | input | 1 | Completion interrupt acknowledge |
| xfer_strobe | output | 1 | DMA transfer this cycle |
| cpu_slot | output | 1 | Bus granted to CPU this cycle |
| count_o | output | CW | Remaining byte count |
| go_o | output | 1 | Channel running |
| done_o | output | 1 | Job complete |
| dma_irq | output | 1 | Completion interrupt |
| fifo_irq | output | 1 | Gated FIFO service interrupt |

## Verification
A wrong state shows at the ports in the very cycle it exists. A missed or extra strobe shifts `count_o` away from the arithmetic countdown on the following cycle. A wrong alternation shows as two adjacent strobes, or as a CPU cycle where demand should win. A faulty completion path leaves `go_o` or `done_o` wrong on the cycle right after the final strobe. The bench sweeps every mode over counts 1 to 5 with two demand patterns, and compares strobe, slot and count on every cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    typedef enum logic [1:0] {
        MODE_BURST  = 2'd0,
        MODE_DEMAND = 2'd1,
        MODE_ALT    = 2'd2,
        MODE_ALTDMD = 2'd3
    } dma_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_BURST     = 3'd1,
        ST_DMD_ARMED = 3'd2,
        ST_ALT_RUN   = 3'd3,
        ST_ALT_GAP   = 3'd4,
        ST_ADM_ARMED = 3'd5,
        ST_ADM_GAP   = 3'd6
    } dma_state_e;
endpackage

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          last,
    output logic          load_zero
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec) begin
            count <= count - ONE;
        end
    end

    assign last      = (count == ONE);
    assign load_zero = (load_val == '0);
endmodule

// File: rtl/dma_slot_fsm.sv
module dma_slot_fsm
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  dma_mode_e start_mode,
    input  logic      halt,
    input  logic      dreq,
    input  logic      last,
    output logic      xfer_strobe,
    output logic      cpu_slot
);
    dma_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start) begin
            unique case (start_mode)
                MODE_BURST:  state_d = ST_BURST;
                MODE_DEMAND: state_d = ST_DMD_ARMED;
                MODE_ALT:    state_d = ST_ALT_RUN;
                MODE_ALTDMD: state_d = ST_ADM_ARMED;
                default:     state_d = ST_IDLE;
            endcase
        end else if (halt) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_BURST:     state_d = last ? ST_IDLE : ST_BURST;
                ST_DMD_ARMED: state_d = (dreq && last) ? ST_IDLE : ST_DMD_ARMED;
                ST_ALT_RUN:   state_d = last ? ST_IDLE : ST_ALT_GAP;
                ST_ALT_GAP:   state_d = ST_ALT_RUN;
                ST_ADM_ARMED: begin
                    if (dreq) state_d = last ? ST_IDLE : ST_ADM_GAP;
                    else      state_d = ST_ADM_ARMED;
                end
                ST_ADM_GAP:   state_d = ST_ADM_ARMED;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        xfer_strobe = 1'b0;
        cpu_slot    = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_ALT_GAP, ST_ADM_GAP: begin
                xfer_strobe = 1'b0;
                cpu_slot    = 1'b1;
            end
            ST_BURST, ST_ALT_RUN: begin
                xfer_strobe = 1'b1;
                cpu_slot    = 1'b0;
            end
            ST_DMD_ARMED, ST_ADM_ARMED: begin
                xfer_strobe = dreq;
                cpu_slot    = !dreq;
            end
            default: begin
                xfer_strobe = 1'b0;
                cpu_slot    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dma_irq_gate.sv
module dma_irq_gate (
    input  logic done,
    input  logic ie,
    input  logic burst_active,
    input  logic go,
    input  logic fifo_sel,
    input  logic fifo_req,
    output logic dma_irq,
    output logic fifo_irq
);
    logic fifo_owned;

    assign fifo_owned = go && fifo_sel;
    assign dma_irq    = done && ie && !burst_active;
    assign fifo_irq   = fifo_req && !fifo_owned && !burst_active;
endmodule

// File: rtl/dma_slot_sequencer.sv
module dma_slot_sequencer
    import dma_seq_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_go,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_ie,
    input  logic          cfg_fifo,
    input  logic [CW-1:0] cfg_count,
    input  logic          dreq,
    input  logic          fifo_req,
    input  logic          int_ack,
    output logic          xfer_strobe,
    output logic          cpu_slot,
    output logic [CW-1:0] count_o,
    output logic          go_o,
    output logic          done_o,
    output logic          dma_irq,
    output logic          fifo_irq
);
    logic      go_q, done_q, ie_q, fifo_sel_q;
    dma_mode_e mode_q;
    logic      last, load_zero, start, halt, finish, burst_active;

    assign start        = cfg_we && cfg_go && !load_zero;
    assign halt         = cfg_we && !start;
    assign finish       = xfer_strobe && last && !cfg_we;
    assign burst_active = go_q && (mode_q == MODE_BURST);

    dma_count_unit #(.CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_we),
        .load_val  (cfg_count),
        .dec       (xfer_strobe),
        .count     (count_o),
        .last      (last),
        .load_zero (load_zero)
    );

    dma_slot_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_mode  (dma_mode_e'(cfg_mode)),
        .halt        (halt),
        .dreq        (dreq),
        .last        (last),
        .xfer_strobe (xfer_strobe),
        .cpu_slot    (cpu_slot)
    );

    // control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q       <= 1'b0;
            done_q     <= 1'b0;
            ie_q       <= 1'b0;
            fifo_sel_q <= 1'b0;
            mode_q     <= MODE_BURST;
        end else if (cfg_we) begin
            go_q       <= start;
            ie_q       <= cfg_ie;
            fifo_sel_q <= cfg_fifo;
            mode_q     <= dma_mode_e'(cfg_mode);
            if (cfg_go) done_q <= load_zero;
        end else begin
            if (finish) begin
                go_q   <= 1'b0;
                done_q <= 1'b1;
            end else if (int_ack && done_q && !burst_active) begin
                done_q <= 1'b0;
            end
        end
    end

    assign go_o   = go_q;
    assign done_o = done_q;

    dma_irq_gate u_irq (
        .done         (done_q),
        .ie           (ie_q),
        .burst_active (burst_active),
        .go           (go_q),
        .fifo_sel     (fifo_sel_q),
        .fifo_req     (fifo_req),
        .dma_irq      (dma_irq),
        .fifo_irq     (fifo_irq)
    );
endmodule

// File: rtl/dma_seq_checker.sv
module dma_seq_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic          dreq,
    input logic          int_ack,
    input logic          xfer_strobe,
    input logic [CW-1:0] count_o,
    input logic          go_o,
    input logic          done_o,
    input logic          dma_irq,
    input logic          fifo_irq,
    input logic [1:0]    mode_q,
    input logic          fifo_sel_q
);
    a_r3_finish_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && count_o == CW'(1) && !cfg_we) |=> (!go_o && done_o));

    a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && !cfg_we) |=> (count_o == $past(count_o) - CW'(1)));

    a_r5_demand_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && mode_q == 2'd1 && dreq) |-> xfer_strobe);

    a_r6_alt_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && mode_q[1] && !cfg_we) |=> !xfer_strobe);

    a_r8_burst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && mode_q == 2'd0) |-> (!dma_irq && !fifo_irq));

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && int_ack && !cfg_we) |=> !done_o);

    a_r10_fifo_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (go_o && fifo_sel_q) |-> !fifo_irq);

    a_r2_strobe_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strobe |-> go_o);
endmodule

bind dma_slot_sequencer dma_seq_checker #(.CW(CW)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .dreq        (dreq),
    .int_ack     (int_ack),
    .xfer_strobe (xfer_strobe),
    .count_o     (count_o),
    .go_o        (go_o),
    .done_o      (done_o),
    .dma_irq     (dma_irq),
    .fifo_irq    (fifo_irq),
    .mode_q      (mode_q),
    .fifo_sel_q  (fifo_sel_q)
);

// File: tb/dma_slot_sequencer_test.sv
module dma_slot_sequencer_test;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_go = 1'b0, cfg_ie = 1'b0, cfg_fifo = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [CW-1:0] cfg_count = '0;
    logic          dreq = 1'b0, fifo_req = 1'b0, int_ack = 1'b0;
    logic          xfer_strobe, cpu_slot, go_o, done_o, dma_irq, fifo_irq;
    logic [CW-1:0] count_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dma_slot_sequencer #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_go(cfg_go),
        .cfg_mode(cfg_mode), .cfg_ie(cfg_ie), .cfg_fifo(cfg_fifo),
        .cfg_count(cfg_count), .dreq(dreq), .fifo_req(fifo_req),
        .int_ack(int_ack), .xfer_strobe(xfer_strobe), .cpu_slot(cpu_slot),
        .count_o(count_o), .go_o(go_o), .done_o(done_o),
        .dma_irq(dma_irq), .fifo_irq(fifo_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input bit go, input int mode, input bit ie,
                             input bit fsel, input int cnt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_go = go; cfg_mode = 2'(mode);
        cfg_ie = ie; cfg_fifo = fsel; cfg_count = CW'(cnt);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_job(input int mode, input int n, input int pat,
                           input bit ie, input bit fsel);
        int  rem = n;
        int  cyc = 0;
        bit  gap = 1'b0;
        bit  expx;
        fifo_req = 1'b1;
        write_cfg(1'b1, mode, ie, fsel, n);
        while (rem > 0 && cyc < 100) begin
            dreq = (pat == 1) ? ((cyc % 3) != 2) : 1'b1;
            #1;
            case (mode)
                0:       expx = 1'b1;
                1:       expx = dreq;
                2:       expx = !gap;
                default: expx = dreq && !gap;
            endcase
            if (mode == 0) chk("R4 burst strobe", int'(xfer_strobe), int'(expx));
            else if (mode == 1) chk("R5 demand strobe", int'(xfer_strobe), int'(expx));
            else if (mode == 2) chk("R6 alternate strobe", int'(xfer_strobe), int'(expx));
            else chk("R7 alt-demand strobe", int'(xfer_strobe), int'(expx));
            chk("R12 cpu slot", int'(cpu_slot), int'(!expx));
            chk("R3 count", int'(count_o), rem);
            chk("R2 go running", int'(go_o), 1);
            chk("R10 fifo irq while running", int'(fifo_irq),
                (fsel || mode == 0) ? 0 : 1);
            chk("R8 irq while running", int'(dma_irq), 0);
            if (expx) rem--;
            gap = expx && (mode >= 2);
            cyc++;
            @(negedge clk);
        end
        #1;
        chk("R3 go cleared", int'(go_o), 0);
        chk("R3 done set", int'(done_o), 1);
        chk("R3 count zero", int'(count_o), 0);
        chk("R12 idle strobe", int'(xfer_strobe), 0);
        chk("R8 completion irq", int'(dma_irq), int'(ie));
        chk("R10 fifo irq after job", int'(fifo_irq), 1);
        if (mode == 0) chk("R4 burst length", cyc, n);
        if (mode == 2) chk("R6 alternate length", cyc, 2 * n - 1);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        #1;
        chk("R9 ack clears done", int'(done_o), 0);
        chk("R8 irq after ack", int'(dma_irq), 0);
        dreq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 go", int'(go_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 count", int'(count_o), 0);
        chk("R1 strobe", int'(xfer_strobe), 0);
        chk("R1 cpu slot", int'(cpu_slot), 1);
        chk("R1 dma irq", int'(dma_irq), 0);
        chk("R1 fifo irq", int'(fifo_irq), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++)
            for (int n = 1; n <= 5; n++)
                for (int p = 0; p < 2; p++)
                    run_job(m, n, p, n[0], p[0]);

        // R5: no demand, no transfer
        write_cfg(1'b1, 1, 1'b0, 1'b0, 4);
        dreq = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R5 idle without demand", int'(xfer_strobe), 0);
            chk("R5 count held", int'(count_o), 4);
            @(negedge clk);
        end
        // R2: stop with go=0 mid-job
        dreq = 1'b1;
        #1;
        chk("R5 demand resumes", int'(xfer_strobe), 1);
        write_cfg(1'b0, 1, 1'b0, 1'b0, 3);
        #1;
        chk("R2 stop strobe", int'(xfer_strobe), 0);
        chk("R2 stop go", int'(go_o), 0);
        chk("R2 stop done kept", int'(done_o), 0);
        chk("R2 stop count loaded", int'(count_o), 3);
        @(negedge clk);
        #1;
        chk("R2 stays stopped", int'(xfer_strobe), 0);
        dreq = 1'b0;

        // R11: zero count start
        write_cfg(1'b1, 0, 1'b1, 1'b0, 0);
        #1;
        chk("R11 go", int'(go_o), 0);
        chk("R11 done", int'(done_o), 1);
        chk("R11 no strobe", int'(xfer_strobe), 0);
        chk("R8 irq on zero count", int'(dma_irq), 1);

        // R2: restart clears done
        write_cfg(1'b1, 2, 1'b0, 1'b0, 2);
        #1;
        chk("R2 restart clears done", int'(done_o), 0);
        chk("R2 restart go", int'(go_o), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule